// File: doc/BRIEF.md
# Synthesizer Programming Slave (I2C)

This block is the serial programming front end of a PLL frequency synthesizer. It watches an oversampled two-wire bus (SCL and SDA), recognises its own device address and steers the written bytes into three holding registers: a 15-bit divider ratio, a 7-bit control word and a 4-bit port word. Each register comes with a one-cycle load strobe for the synthesizer core. In read mode it returns a status byte. That byte reports a power-on flag, the loop lock flag, the levels on three port pins and a 3-bit ADC code.

Data bytes arrive in pairs. The most significant bit of the first byte of a pair selects the kind of pair. A 0 opens a divider pair, and the divider only loads once both halves are in. A 1 opens a control/port pair, and each of those two registers loads as soon as its own byte ends. Pairs may follow one another in any order inside one transfer. In read mode the status byte repeats for as long as the master acknowledges.

Top module: `synth_i2c_if`

## Requirements
- R1: An address byte has bits [7:3] = 11000, bits [2:1] = select field and bit 0 = direction (1 = read). The slave accepts the byte when the select field is 01. It also accepts it when the select field equals `addrSel` (00, 10 or 11). With `addrSel` = 01 only the 01 field matches. After a non-matching address the slave acknowledges nothing and changes no register until the next START.
- R2: The slave pulls SDA low during the ninth clock after a matching address, and again after every data byte written within that transfer.
- R3: In a write transfer, a first-of-pair byte with bit 7 = 0 holds divider bits [14:8] in its bits [6:0]. The next byte holds divider bits [7:0]. `divRatio` changes only at the end of that second byte, with a one-cycle `divLoad` pulse.
- R4: A first-of-pair byte with bit 7 = 1 loads its bits [6:0] into `ctrlReg`, with a `ctrlLoad` pulse. The next byte loads `portReg` = {bit6, bit2, bit1, bit0}, with a `portLoad` pulse.
- R5: Pairs may follow each other in any order without a new address. A STOP or START closes any half-finished pair, so the next data byte is again a first-of-pair byte.
- R6: A read returns the status byte MSB first: {POR, lockIn, portIn[0], portIn[1], portIn[2], adcCode[2:0]}.
- R7: The status byte is sent again each time the master acknowledges. After a master not-acknowledge the slave releases SDA and keeps it released until the next START.
- R8: The POR flag is 1 after reset and is set while `underVolt` is high. A STOP that ends a read transfer clears it.
- R9: After reset `divRatio`, `ctrlReg` and `portReg` are 0 (ports P0..P2 active, P6 off), the load strobes are low and `sdaPullLow` is low.
- R10: A register and its load strobe change on the third rising `clk` edge after the eighth SCL rise of the byte reaches `sclIn`. This latency comes from two synchronizer flops plus one edge-detect flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaPullLow | output | 1 | 1 drives the open-drain SDA low |
| addrSel | input | 2 | Address select code from the external comparator |
| underVolt | input | 1 | Supply undervoltage indication |
| lockIn | input | 1 | PLL lock indication |
| portIn | input | 3 | Port pin levels P0, P1, P2 in bits 0, 1, 2 |
| adcCode | input | 3 | ADC conversion code |
| divRatio | output | 15 | Programmable divider ratio |
| divLoad | output | 1 | One-cycle pulse when divRatio updates |
| ctrlReg | output | 7 | Control word |
| ctrlLoad | output | 1 | One-cycle pulse when ctrlReg updates |
| portReg | output | 4 | Port word {P6, P2, P1, P0} |
| portLoad | output | 1 | One-cycle pulse when portReg updates |

## Verification
A stale pair-tracking bit shows up at the register outputs within one byte. The following byte then lands in the wrong register, or a divider load fires a byte early, and the per-cycle comparison catches it in the very cycle the strobe should or should not rise. A wrong bit counter or acknowledge phase shows at the master's ninth-clock sample as a missing or spurious acknowledge. It also shows as shifted status bits on the next read. A POR flag that fails to clear, or fails to set, is visible in the most significant status bit on the very next read transfer.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WR,
    ST_RD,
    ST_MACK,
    ST_HOLD
  } busState_t;

  // strobes from the bus control to the register datapath
  typedef struct packed {
    logic divHiStore;
    logic divWrite;
    logic ctrlWrite;
    logic portWrite;
    logic porClear;
  } regStrobe_t;

  localparam logic [4:0] ADDR_PREFIX = 5'b11000;
  localparam logic [1:0] FIXED_SEL   = 2'b01;

endpackage

// File: rtl/synth_i2c_sync.sv
module synth_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/synth_i2c_ctrl.sv
module synth_i2c_ctrl
  import synth_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclS,
  input  logic       sdaS,
  input  logic [1:0] addrSel,
  input  logic [7:0] statusByte,
  output logic       sdaLow,
  output logic [7:0] rxByte,
  output regStrobe_t strobe
);
  busState_t state, ackNext;
  logic       sclPrev, sdaPrev;
  logic [3:0] bitCnt;
  logic [7:0] shiftIn;
  logic [7:0] txByte;
  logic       ackPhase;
  logic       pairOpen, pairIsCtrl;
  logic       readActive;
  logic       masterAck;

  logic sclRise, sclFall, startCond, stopCond, byteDone, addrHit, wrDone;
  logic [7:0] newByte;

  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startCond = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopCond  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign newByte   = {shiftIn[6:0], sdaS};
  assign byteDone  = sclRise && (bitCnt == 4'd7);
  assign addrHit   = (newByte[7:3] == ADDR_PREFIX) &&
                     ((newByte[2:1] == FIXED_SEL) || (newByte[2:1] == addrSel));
  assign wrDone    = (state == ST_WR) && byteDone && !startCond && !stopCond;
  assign rxByte    = newByte;

  always_comb begin
    strobe            = '0;
    strobe.divHiStore = wrDone && !pairOpen && !newByte[7];
    strobe.ctrlWrite  = wrDone && !pairOpen &&  newByte[7];
    strobe.divWrite   = wrDone &&  pairOpen && !pairIsCtrl;
    strobe.portWrite  = wrDone &&  pairOpen &&  pairIsCtrl;
    strobe.porClear   = stopCond && readActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      ackNext    <= ST_WR;
      sclPrev    <= 1'b1;
      sdaPrev    <= 1'b1;
      bitCnt     <= '0;
      shiftIn    <= '0;
      txByte     <= '0;
      ackPhase   <= 1'b0;
      pairOpen   <= 1'b0;
      pairIsCtrl <= 1'b0;
      readActive <= 1'b0;
      masterAck  <= 1'b0;
      sdaLow     <= 1'b0;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      if (stopCond) begin
        state      <= ST_IDLE;
        sdaLow     <= 1'b0;
        pairOpen   <= 1'b0;
        readActive <= 1'b0;
      end else if (startCond) begin
        state      <= ST_ADDR;
        bitCnt     <= '0;
        sdaLow     <= 1'b0;
        pairOpen   <= 1'b0;
        readActive <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (sclRise) begin
            shiftIn <= newByte;
            if (bitCnt == 4'd7) begin
              bitCnt <= '0;
              if (addrHit) begin
                state      <= ST_ACK;
                ackPhase   <= 1'b0;
                ackNext    <= newByte[0] ? ST_RD : ST_WR;
                readActive <= newByte[0];
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              bitCnt <= bitCnt + 4'd1;
            end
          end
          ST_WR: if (sclRise) begin
            shiftIn <= newByte;
            if (bitCnt == 4'd7) begin
              bitCnt <= '0;
              if (!pairOpen) begin
                pairOpen   <= 1'b1;
                pairIsCtrl <= newByte[7];
              end else begin
                pairOpen <= 1'b0;
              end
              state    <= ST_ACK;
              ackPhase <= 1'b0;
              ackNext  <= ST_WR;
            end else begin
              bitCnt <= bitCnt + 4'd1;
            end
          end
          ST_ACK: if (sclFall) begin
            if (!ackPhase) begin
              ackPhase <= 1'b1;
              sdaLow   <= 1'b1;
            end else begin
              ackPhase <= 1'b0;
              bitCnt   <= '0;
              if (ackNext == ST_RD) begin
                txByte <= statusByte;
                sdaLow <= ~statusByte[7];
                state  <= ST_RD;
              end else begin
                sdaLow <= 1'b0;
                state  <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (sclRise) bitCnt <= bitCnt + 4'd1;
            if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaLow <= 1'b0;
                state  <= ST_MACK;
              end else begin
                txByte <= {txByte[6:0], 1'b0};
                sdaLow <= ~txByte[6];
              end
            end
          end
          ST_MACK: begin
            if (sclRise) masterAck <= ~sdaS;
            if (sclFall) begin
              if (masterAck) begin
                txByte <= statusByte;
                sdaLow <= ~statusByte[7];
                bitCnt <= '0;
                state  <= ST_RD;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the slave starts pulling SDA only while SCL is low
  p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaLow) |-> !sclS);
  // R7: after a master not-acknowledge SDA stays released
  p_hold_released_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |-> !sdaLow);
  // R1: an idle (or mismatched) slave never drives the bus
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaLow);
endmodule

// File: rtl/synth_i2c_regs.sv
module synth_i2c_regs
  import synth_i2c_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic [7:0]       rxByte,
  input  logic             underVolt,
  input  logic             lockIn,
  input  logic [2:0]       portIn,
  input  logic [2:0]       adcCode,
  output logic [DIV_W-1:0] divRatio,
  output logic             divLoad,
  output logic [6:0]       ctrlReg,
  output logic             ctrlLoad,
  output logic [3:0]       portReg,
  output logic             portLoad,
  output logic [7:0]       statusByte
);
  localparam int HI_W = DIV_W - 8;

  logic [HI_W-1:0] divHi;
  logic            porFlag;
  logic            porClr;

  assign porClr = strobe.porClear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divHi    <= '0;
      divRatio <= '0;
      ctrlReg  <= '0;
      portReg  <= '0;
      divLoad  <= 1'b0;
      ctrlLoad <= 1'b0;
      portLoad <= 1'b0;
    end else begin
      divLoad  <= strobe.divWrite;
      ctrlLoad <= strobe.ctrlWrite;
      portLoad <= strobe.portWrite;
      if (strobe.divHiStore) divHi    <= rxByte[HI_W-1:0];
      if (strobe.divWrite)   divRatio <= {divHi, rxByte};
      if (strobe.ctrlWrite)  ctrlReg  <= rxByte[6:0];
      if (strobe.portWrite)  portReg  <= {rxByte[6], rxByte[2:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          porFlag <= 1'b1;
    else if (underVolt) porFlag <= 1'b1;
    else if (porClr)    porFlag <= 1'b0;
  end

  assign statusByte = {porFlag, lockIn, portIn[0], portIn[1], portIn[2], adcCode};

  // R3: at most one register is loaded per cycle
  p_single_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({divLoad, ctrlLoad, portLoad}));
  // R3: the divider only moves together with its load pulse
  p_div_change_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divRatio) |-> divLoad);
  // R4: control and port words only move with their pulses
  p_ctrl_change_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlReg) |-> ctrlLoad);
  p_port_change_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portReg) |-> portLoad);
  // R8: POR falls only after a read-ending STOP, rises under undervoltage
  p_por_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(porFlag) |-> $past(porClr));
  p_undervolt_r8: assert property (@(posedge clk) disable iff (!rstN)
    underVolt |=> porFlag);
endmodule

// File: rtl/synth_i2c_if.sv
module synth_i2c_if
  import synth_i2c_pkg::*;
#(
  parameter int DIV_W       = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaPullLow,
  input  logic [1:0]       addrSel,
  input  logic             underVolt,
  input  logic             lockIn,
  input  logic [2:0]       portIn,
  input  logic [2:0]       adcCode,
  output logic [DIV_W-1:0] divRatio,
  output logic             divLoad,
  output logic [6:0]       ctrlReg,
  output logic             ctrlLoad,
  output logic [3:0]       portReg,
  output logic             portLoad
);
  logic       sclS, sdaS;
  logic [7:0] rxByte;
  logic [7:0] statusByte;
  regStrobe_t strobe;

  synth_i2c_sync #(.STAGES(SYNC_STAGES)) u_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));
  synth_i2c_sync #(.STAGES(SYNC_STAGES)) u_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));

  synth_i2c_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS), .addrSel(addrSel),
    .statusByte(statusByte), .sdaLow(sdaPullLow), .rxByte(rxByte), .strobe(strobe));

  synth_i2c_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .underVolt(underVolt), .lockIn(lockIn), .portIn(portIn), .adcCode(adcCode),
    .divRatio(divRatio), .divLoad(divLoad), .ctrlReg(ctrlReg), .ctrlLoad(ctrlLoad),
    .portReg(portReg), .portLoad(portLoad), .statusByte(statusByte));
endmodule

// File: tb/synth_i2c_if_tb.sv
module synth_i2c_if_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H = 6;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaIn, sdaPullLow;
  logic [1:0] addrSel = 2'b00;
  logic underVolt = 1'b0, lockIn = 1'b0;
  logic [2:0] portIn = 3'b000, adcCode = 3'b000;
  logic [14:0] divRatio;
  logic [6:0] ctrlReg;
  logic [3:0] portReg;
  logic divLoad, ctrlLoad, portLoad;

  assign sdaIn = sdaM & ~sdaPullLow;

  synth_i2c_if u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaIn), .sdaPullLow(sdaPullLow),
    .addrSel(addrSel), .underVolt(underVolt), .lockIn(lockIn), .portIn(portIn),
    .adcCode(adcCode), .divRatio(divRatio), .divLoad(divLoad), .ctrlReg(ctrlReg),
    .ctrlLoad(ctrlLoad), .portReg(portReg), .portLoad(portLoad));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFails = 0;
  bit cmpOn = 0, done = 0;

  // behavioural model state
  int expDiv = 0, expCtrl = 0, expPort = 0;
  bit expDivLd, expCtrlLd, expPortLd;
  int dueQ[$], kindQ[$], valQ[$];
  bit wrActive = 0, rdActive = 0, pOpen = 0, pCtrl = 0;
  int hiM = 0;
  bit porM = 1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn) begin
      expDivLd = 0; expCtrlLd = 0; expPortLd = 0;
      while (dueQ.size() > 0 && dueQ[0] == cyc) begin
        int k, v;
        k = kindQ.pop_front();
        v = valQ.pop_front();
        void'(dueQ.pop_front());
        if (k == 1) begin expDiv = v; expDivLd = 1; end
        if (k == 2) begin expCtrl = v; expCtrlLd = 1; end
        if (k == 3) begin expPort = v; expPortLd = 1; end
      end
      nChecks++;
      if (int'(divRatio) != expDiv || divLoad != expDivLd ||
          int'(ctrlReg) != expCtrl || ctrlLoad != expCtrlLd ||
          int'(portReg) != expPort || portLoad != expPortLd) begin
        nFails++;
        $display("FAIL R3 R4 R10 cyc %0d actual div %h/%b ctrl %h/%b port %h/%b expected div %h/%b ctrl %h/%b port %h/%b",
                 cyc, divRatio, divLoad, ctrlReg, ctrlLoad, portReg, portLoad,
                 expDiv, expDivLd, expCtrl, expCtrlLd, expPort, expPortLd);
      end
    end
  end

  task automatic schedule(int due, int kind, int val);
    dueQ.push_back(due); kindQ.push_back(kind); valQ.push_back(val);
  endtask

  task automatic busStart();
    @(negedge clk); sdaM = 1'b1;
    repeat (H) @(negedge clk); sclM = 1'b1;
    repeat (H) @(negedge clk); sdaM = 1'b0;
    repeat (H) @(negedge clk); sclM = 1'b0;
    pOpen = 0; wrActive = 0; rdActive = 0;
  endtask

  task automatic busStop();
    @(negedge clk); sdaM = 1'b0;
    repeat (H) @(negedge clk); sclM = 1'b1;
    repeat (H) @(negedge clk); sdaM = 1'b1;
    if (rdActive) porM = 0;
    repeat (H) @(negedge clk);
    pOpen = 0; wrActive = 0; rdActive = 0;
  endtask

  // sends one byte; model decides the register effect from the requirements
  task automatic sendByte(logic [7:0] b, bit expAck, string req);
    int kind = 0, val = 0;
    bit ack;
    if (wrActive) begin
      if (!pOpen) begin
        pOpen = 1; pCtrl = b[7];
        if (b[7]) begin kind = 2; val = int'(b[6:0]); end
        else hiM = int'(b[6:0]);
      end else begin
        pOpen = 0;
        if (pCtrl) begin kind = 3; val = int'({b[6], b[2:0]}); end
        else begin kind = 1; val = (hiM << 8) | int'(b); end
      end
    end
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sdaM = b[i];
      repeat (H) @(negedge clk); sclM = 1'b1;
      if (i == 0 && kind != 0) schedule(cyc + LAT, kind, val);
      repeat (H) @(negedge clk); sclM = 1'b0;
    end
    @(negedge clk); sdaM = 1'b1;
    repeat (H) @(negedge clk); sclM = 1'b1;
    repeat (H/2) @(negedge clk); ack = !sdaIn;
    check(ack == expAck, req, "acknowledge", int'(ack), int'(expAck));
    repeat (H - H/2) @(negedge clk); sclM = 1'b0;
  endtask

  task automatic addrByte(logic [7:0] a, bit expAck, string req);
    sendByte(a, expAck, req);
    wrActive = expAck && !a[0];
    rdActive = expAck && a[0];
  endtask

  task automatic recvByte(bit mAck, logic [7:0] expB, string req);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sdaM = 1'b1;
      repeat (H) @(negedge clk); sclM = 1'b1;
      repeat (H/2) @(negedge clk); v[i] = sdaIn;
      repeat (H - H/2) @(negedge clk); sclM = 1'b0;
    end
    check(v == expB, req, "status byte", int'(v), int'(expB));
    @(negedge clk); sdaM = mAck ? 1'b0 : 1'b1;
    repeat (H) @(negedge clk); sclM = 1'b1;
    repeat (H) @(negedge clk); sclM = 1'b0;
    @(negedge clk); sdaM = 1'b1;
  endtask

  function automatic logic [7:0] expStatus();
    return {porM, lockIn, portIn[0], portIn[1], portIn[2], adcCode};
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    check(divRatio == 0 && ctrlReg == 0, "R9", "div/ctrl after reset", int'(divRatio), 0);
    check(portReg == 4'h0, "R9", "port after reset", int'(portReg), 0);
    check(!divLoad && !ctrlLoad && !portLoad && !sdaPullLow, "R9", "strobes after reset",
          int'({divLoad, ctrlLoad, portLoad, sdaPullLow}), 0);
    rstN = 1'b1;
    cmpOn = 1;
    repeat (4) @(negedge clk);

    // R1 R2 R3 R4: full programming with select code 00
    addrSel = 2'b00;
    busStart(); addrByte(8'hC0, 1, "R1");
    sendByte(8'h12, 1, "R2"); sendByte(8'h34, 1, "R3");
    sendByte(8'hD5, 1, "R4"); sendByte(8'h47, 1, "R4");
    busStop();

    // R5: pairs in the other order without re-addressing
    busStart(); addrByte(8'hC2, 1, "R1");
    sendByte(8'h8A, 1, "R5"); sendByte(8'h05, 1, "R5");
    sendByte(8'h7F, 1, "R5"); sendByte(8'hFF, 1, "R5");
    busStop();

    // R5: a STOP abandons a half pair, next byte starts a new pair
    busStart(); addrByte(8'hC2, 1, "R1"); sendByte(8'h01, 1, "R5"); busStop();
    busStart(); addrByte(8'hC2, 1, "R1");
    sendByte(8'h02, 1, "R5"); sendByte(8'h03, 1, "R5");
    // R5: a repeated START also closes the pair
    sendByte(8'h09, 1, "R5");
    busStart(); addrByte(8'hC2, 1, "R1"); sendByte(8'hA0, 1, "R5");
    sendByte(8'h41, 1, "R5");
    busStop();

    // R1: mismatched address ignored, following bytes not acknowledged
    busStart(); addrByte(8'hC4, 0, "R1");
    sendByte(8'h00, 0, "R1"); sendByte(8'h11, 0, "R1");
    busStop();

    // R1: address select table
    addrSel = 2'b10;
    busStart(); addrByte(8'hC4, 1, "R1"); busStop();
    busStart(); addrByte(8'hC0, 0, "R1"); busStop();
    addrSel = 2'b11;
    busStart(); addrByte(8'hC6, 1, "R1"); busStop();
    busStart(); addrByte(8'hC4, 0, "R1"); busStop();
    addrSel = 2'b01;
    busStart(); addrByte(8'hC0, 0, "R1"); busStop();
    busStart(); addrByte(8'hC6, 0, "R1"); busStop();
    busStart(); addrByte(8'hC2, 1, "R1"); busStop();
    busStart(); addrByte(8'h42, 0, "R1"); busStop();

    // R6 R7 R8: read, repeated status, POR still set
    lockIn = 1'b1; portIn = 3'b001; adcCode = 3'b011;
    busStart(); addrByte(8'hC3, 1, "R6");
    recvByte(1, expStatus(), "R6");
    recvByte(0, expStatus(), "R7");
    busStop();

    // R8: POR cleared by the read-ending STOP; R7: release after NACK
    lockIn = 1'b0; portIn = 3'b110; adcCode = 3'b100;
    busStart(); addrByte(8'hC3, 1, "R8");
    recvByte(0, expStatus(), "R8");
    repeat (3*H) @(negedge clk);
    check(!sdaPullLow, "R7", "SDA after not-acknowledge", int'(sdaPullLow), 0);
    begin
      logic v;
      @(negedge clk); sclM = 1'b1;
      repeat (H/2) @(negedge clk); v = sdaIn;
      check(v == 1'b1, "R7", "bus level after not-acknowledge", int'(v), 1);
      repeat (H - H/2) @(negedge clk); sclM = 1'b0;
    end
    busStop();

    // R8: undervoltage sets POR again
    @(negedge clk); underVolt = 1'b1;
    @(negedge clk); underVolt = 1'b0; porM = 1;
    busStart(); addrByte(8'hC3, 1, "R8");
    recvByte(0, expStatus(), "R8");
    busStop();

    // R8: a write-ending STOP does not clear POR
    busStart(); addrByte(8'hC2, 1, "R8"); busStop();
    busStart(); addrByte(8'hC3, 1, "R8");
    recvByte(0, expStatus(), "R8");
    busStop();

    repeat (10) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule